// File: doc/BRIEF.md
# Strided Vector Load Scheduler for Interleaved Banks

This block issues the element reads of one strided vector load to a memory that is split into interleaved banks. A start pulse captures a base address, a stride counted in elements and a vector length. From then on the scheduler offers at most one element per cycle, strictly in element order. The element's bank is the low bits of its address. A bank that has just served an access is unavailable for a fixed number of cycles. When the next element's bank is still unavailable, the scheduler raises a stall flag and waits instead of running ahead.

Each issued element comes back on a return stream a fixed number of cycles later, with its index and the word read from the bank. Strides that land on few distinct banks therefore serialize at the bank busy time, while strides that rotate through enough banks stream at full rate. A cycle counter runs from the first cycle of the load and freezes when the load is complete, so that the total latency of a load can be compared with closed-form results. The bank contents are register arrays filled with a fixed pattern at reset. The block performs no writes.

Top module: `stride_load_sched`

## Requirements
- R1: While reset is high and in the cycle after it, `done`, `req_valid`, `stall` and `rsp_valid` are 0 and `cyc_count` is 0.
- R2: A `start` pulse seen while no load is running begins a load: the cycle right after it is cycle 0 of the load and has `cyc_count` = 0. A `start` seen while a load is running is ignored and does not change that load's requests, data or timing.
- R3: Element k has the address (base + k*stride) mod 2^ADDR_W. Its bank is the address mod 8, that is, the three low address bits. `req_addr` shows this address.
- R4: Requests come out in element order. There is at most one request per cycle, `req_idx` runs 0, 1, 2, … and exactly `vec_len` requests are made.
- R5: A bank that was accessed in cycle c can be accessed again at the earliest in cycle c+6. An element is issued in the first cycle in which its bank is free. `stall` is 1 in every cycle in which elements remain to be issued and none is issued.
- R6: The element issued in cycle c returns in cycle c+12, with `rsp_idx` equal to its index. `rsp_data` is the word at the element's address A, which is (A*257 + 0x1234) mod 2^16.
- R7: `done` rises in the cycle after the last element returns, and `cyc_count` then equals the total latency. With stride 1 and 64 elements this is 12+64 = 76. With stride 32 and 64 elements it is 12+1+6*63 = 391.
- R8: `done` stays at 1 and `cyc_count` stays frozen until the next accepted `start`. The cycle after that start shows `done` = 0.
- R9: A load of length 0 makes no request and shows `done` = 1 with `cyc_count` = 1 in cycle 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while one is running) |
| base_addr | input | ADDR_W | Element address of element 0 |
| stride | input | ADDR_W | Distance between elements, in elements |
| vec_len | input | LEN_W | Number of elements |
| req_valid | output | 1 | An element is issued this cycle |
| req_idx | output | LEN_W | Index of the issued element |
| req_addr | output | ADDR_W | Address of the issued element |
| stall | output | 1 | An element is pending but its bank is busy |
| rsp_valid | output | 1 | An element's data returns this cycle |
| rsp_idx | output | LEN_W | Index of the returning element |
| rsp_data | output | DATA_W | Word read for the returning element |
| done | output | 1 | Load complete; held until the next start |
| cyc_count | output | CYC_W | Cycles since the load began, frozen at completion |

## Verification
On every cycle the assertions check the bank spacing of requests: each bank's gap since its previous request is at least the busy time. They also check that request indices and addresses step by one element and by the latched stride, that returns arrive in index order, that nothing is issued, stalled or returned while `done` is high, that the counter is frozen while `done` holds, and that a start during a load never restarts element 0. Only the bench's scenarios can show the exact cycle of each issue and return, the stall counts and the closed-form totals for each stride class, the read data pattern, and the zero-length case. The bench computes these from the number of distinct banks that a stride visits.

// File: rtl/sls_pkg.sv
package sls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } phase_e;

  // Reset fill pattern of the bank storage, indexed by global element address.
  function automatic logic [31:0] fill_word(input int unsigned a);
    return a * 32'd257 + 32'h0000_1234;
  endfunction

endpackage

// File: rtl/sls_bank_busy.sv
module sls_bank_busy #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue,
  input  logic [BANK_W-1:0]    issue_bank,
  output logic [NUM_BANKS-1:0] bank_free
);

  localparam int CNT_W = $clog2(BANK_BUSY + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BANK_BUSY - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        left_q <= '0;
      end else if (issue && (issue_bank == BANK_W'(b))) begin
        left_q <= RELOAD;
      end else if (left_q != '0) begin
        left_q <= left_q - CNT_W'(1);
      end
    end

    assign bank_free[b] = (left_q == '0);
  end

endmodule

// File: rtl/sls_bank_store.sv
module sls_bank_store
  import sls_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_idx,
  output logic              out_valid,
  output logic [LEN_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int ROWS   = 1 << ROW_W;

  logic [BANK_W-1:0] rd_bank;
  logic [ROW_W-1:0]  rd_row;
  logic [BANK_W-1:0] sel_q;
  logic [DATA_W-1:0] bank_rd [NUM_BANKS];

  assign rd_bank = rd_addr[BANK_W-1:0];
  assign rd_row  = rd_addr[ADDR_W-1:BANK_W];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [ROWS];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int r = 0; r < ROWS; r++) begin
          mem[r] <= DATA_W'(fill_word(r * NUM_BANKS + b));
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rd_en && (rd_bank == BANK_W'(b))) begin
        rd_q <= mem[rd_row];
      end
    end

    assign bank_rd[b] = rd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      sel_q     <= '0;
    end else begin
      out_valid <= rd_en;
      if (rd_en) begin
        out_idx <= rd_idx;
        sel_q   <= rd_bank;
      end
    end
  end

  assign out_data = bank_rd[sel_q];

endmodule

// File: rtl/sls_ret_pipe.sv
module sls_ret_pipe #(
  parameter int DEPTH  = 11,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LEN_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [LEN_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);

  typedef struct packed {
    logic              v;
    logic [LEN_W-1:0]  idx;
    logic [DATA_W-1:0] d;
  } ent_t;

  ent_t stg [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= '{v: in_valid, idx: in_idx, d: in_data};
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign out_valid = stg[DEPTH-1].v;
  assign out_idx   = stg[DEPTH-1].idx;
  assign out_data  = stg[DEPTH-1].d;

endmodule

// File: rtl/stride_load_sched.sv
module stride_load_sched
  import sls_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int MEM_LAT   = 12,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int LEN_W     = 8,
  parameter int CYC_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] stride,
  input  logic [LEN_W-1:0]  vec_len,
  output logic              req_valid,
  output logic [LEN_W-1:0]  req_idx,
  output logic [ADDR_W-1:0] req_addr,
  output logic              stall,
  output logic              rsp_valid,
  output logic [LEN_W-1:0]  rsp_idx,
  output logic [DATA_W-1:0] rsp_data,
  output logic              done,
  output logic [CYC_W-1:0]  cyc_count
);

  localparam int BANK_W     = $clog2(NUM_BANKS);
  localparam int PIPE_DEPTH = MEM_LAT - 1;

  phase_e            phase_q;
  logic [ADDR_W-1:0] cur_addr_q, stride_q, req_addr_q;
  logic [LEN_W-1:0]  len_q, issued_q, ret_q, req_idx_q;
  logic [CYC_W-1:0]  cyc_q;
  logic              req_valid_q, stall_q;

  logic              run_q, launch, active, pending, issue, finish;
  logic [ADDR_W-1:0] eff_addr, eff_stride;
  logic [LEN_W-1:0]  eff_len, eff_issued;
  logic [NUM_BANKS-1:0] bank_free;
  logic [BANK_W-1:0] issue_bank;

  logic              rd_valid;
  logic [LEN_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic              ret_valid;

  // Issue selection: element 0 is considered on the same edge as the start.
  assign run_q      = (phase_q == ST_RUN);
  assign launch     = start && !run_q;
  assign active     = launch || run_q;
  assign eff_addr   = launch ? base_addr : cur_addr_q;
  assign eff_stride = launch ? stride    : stride_q;
  assign eff_len    = launch ? vec_len   : len_q;
  assign eff_issued = launch ? '0        : issued_q;
  assign pending    = active && (eff_issued != eff_len);
  assign issue_bank = eff_addr[BANK_W-1:0];
  assign issue      = pending && bank_free[issue_bank];
  assign finish     = run_q &&
                      (({1'b0, ret_q} + (LEN_W+1)'(ret_valid)) == {1'b0, len_q});

  sls_bank_busy #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_BUSY(BANK_BUSY),
    .BANK_W   (BANK_W)
  ) u_busy (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_bank(issue_bank),
    .bank_free (bank_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= ST_IDLE;
      cur_addr_q  <= '0;
      stride_q    <= '0;
      len_q       <= '0;
      issued_q    <= '0;
      ret_q       <= '0;
      cyc_q       <= '0;
      req_valid_q <= 1'b0;
      req_idx_q   <= '0;
      req_addr_q  <= '0;
      stall_q     <= 1'b0;
    end else begin
      if (launch) begin
        phase_q  <= ST_RUN;
        len_q    <= vec_len;
        stride_q <= stride;
        ret_q    <= '0;
        cyc_q    <= '0;
      end else if (run_q) begin
        cyc_q <= cyc_q + CYC_W'(1);
        if (ret_valid) ret_q <= ret_q + LEN_W'(1);
        if (finish)    phase_q <= ST_FIN;
      end

      if (issue) begin
        cur_addr_q <= eff_addr + eff_stride;
        issued_q   <= eff_issued + LEN_W'(1);
        req_idx_q  <= eff_issued;
        req_addr_q <= eff_addr;
      end else if (launch) begin
        cur_addr_q <= base_addr;
        issued_q   <= '0;
      end

      req_valid_q <= issue;
      stall_q     <= pending && !issue;
    end
  end

  sls_bank_store #(
    .NUM_BANKS(NUM_BANKS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (req_valid_q),
    .rd_addr  (req_addr_q),
    .rd_idx   (req_idx_q),
    .out_valid(rd_valid),
    .out_idx  (rd_idx),
    .out_data (rd_data)
  );

  sls_ret_pipe #(
    .DEPTH (PIPE_DEPTH),
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
  ) u_ret (
    .clk      (clk),
    .rst      (rst),
    .in_valid (rd_valid),
    .in_idx   (rd_idx),
    .in_data  (rd_data),
    .out_valid(ret_valid),
    .out_idx  (rsp_idx),
    .out_data (rsp_data)
  );

  assign req_valid = req_valid_q;
  assign req_idx   = req_idx_q;
  assign req_addr  = req_addr_q;
  assign stall     = stall_q;
  assign rsp_valid = ret_valid;
  assign done      = (phase_q == ST_FIN);
  assign cyc_count = cyc_q;

endmodule

// File: rtl/sls_checker.sv
module sls_checker #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int ADDR_W    = 8,
  parameter int LEN_W     = 8,
  parameter int CYC_W     = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              running,
  input logic [ADDR_W-1:0] base_addr,
  input logic [ADDR_W-1:0] stride,
  input logic              req_valid,
  input logic [LEN_W-1:0]  req_idx,
  input logic [ADDR_W-1:0] req_addr,
  input logic              stall,
  input logic              rsp_valid,
  input logic [LEN_W-1:0]  rsp_idx,
  input logic              done,
  input logic [CYC_W-1:0]  cyc_count
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int AGE_W  = $clog2(BANK_BUSY + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(BANK_BUSY);

  logic              accept;
  logic              seen_q, rseen_q;
  logic [LEN_W-1:0]  last_idx_q, last_rsp_q;
  logic [ADDR_W-1:0] last_addr_q, base_l_q, stride_l_q;
  logic [AGE_W-1:0]  age_q [NUM_BANKS];
  logic [BANK_W-1:0] req_bank;

  assign accept   = start && !running;
  assign req_bank = req_addr[BANK_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst)                                           age_q[b] <= AGE_MAX;
      else if (req_valid && (req_bank == BANK_W'(b)))    age_q[b] <= AGE_W'(1);
      else if (age_q[b] != AGE_MAX)                      age_q[b] <= age_q[b] + AGE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q      <= 1'b0;
      rseen_q     <= 1'b0;
      last_idx_q  <= '0;
      last_rsp_q  <= '0;
      last_addr_q <= '0;
      base_l_q    <= '0;
      stride_l_q  <= '0;
    end else begin
      if (accept) begin
        seen_q     <= 1'b0;
        rseen_q    <= 1'b0;
        base_l_q   <= base_addr;
        stride_l_q <= stride;
      end else begin
        if (req_valid) begin
          seen_q      <= 1'b1;
          last_idx_q  <= req_idx;
          last_addr_q <= req_addr;
        end
        if (rsp_valid) begin
          rseen_q    <= 1'b1;
          last_rsp_q <= rsp_idx;
        end
      end
    end
  end

  AST_BANK_SPACING: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (age_q[req_bank] >= AGE_MAX)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seen_q) |-> (req_idx == last_idx_q + LEN_W'(1))); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && seen_q) |-> (req_addr == last_addr_q + stride_l_q)); // R3

  AST_FIRST_ELEM: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !seen_q) |-> (req_idx == '0 && req_addr == base_l_q)); // R3

  AST_RSP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rseen_q) |-> (rsp_idx == last_rsp_q + LEN_W'(1))); // R6

  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rseen_q) |-> (rsp_idx == '0)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!req_valid && !stall && !rsp_valid)); // R7

  AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done && $past(done)) |-> $stable(cyc_count)); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (start && running) |=> !(req_valid && req_idx == '0)); // R2

endmodule

bind stride_load_sched sls_checker #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_BUSY(BANK_BUSY),
  .ADDR_W   (ADDR_W),
  .LEN_W    (LEN_W),
  .CYC_W    (CYC_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .running  (run_q),
  .base_addr(base_addr),
  .stride   (stride),
  .req_valid(req_valid),
  .req_idx  (req_idx),
  .req_addr (req_addr),
  .stall    (stall),
  .rsp_valid(rsp_valid),
  .rsp_idx  (rsp_idx),
  .done     (done),
  .cyc_count(cyc_count)
);

// File: tb/sim_stride_load_sched.sv
module sim_stride_load_sched;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 8;
  localparam int CYC_W  = 16;
  localparam int BUSY   = 6;
  localparam int LAT    = 12;

  typedef struct packed {
    logic [7:0]  base;
    logic [7:0]  strd;
    logic [7:0]  len;
    logic [15:0] cycles;
    logic [15:0] stalls;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,   8'd1,  8'd64, 16'd76,  16'd0},
    '{8'd0,   8'd32, 8'd64, 16'd391, 16'd315},
    '{8'd5,   8'd2,  8'd64, 16'd106, 16'd30},
    '{8'd3,   8'd4,  8'd64, 16'd200, 16'd124},
    '{8'd7,   8'd3,  8'd20, 16'd32,  16'd0},
    '{8'd1,   8'd8,  8'd10, 16'd67,  16'd45},
    '{8'd250, 8'd6,  8'd9,  16'd25,  16'd4},
    '{8'd0,   8'd0,  8'd3,  16'd25,  16'd10},
    '{8'd9,   8'd5,  8'd1,  16'd13,  16'd0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [ADDR_W-1:0] stride = '0;
  logic [LEN_W-1:0]  vec_len = '0;
  logic              req_valid, stall, rsp_valid, done;
  logic [LEN_W-1:0]  req_idx, rsp_idx;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] rsp_data;
  logic [CYC_W-1:0]  cyc_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  stride_load_sched u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .stride(stride), .vec_len(vec_len), .req_valid(req_valid),
    .req_idx(req_idx), .req_addr(req_addr), .stall(stall),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
    .done(done), .cyc_count(cyc_count)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int banks_visited(input int s);
    if ((s & 7) == 0) return 1;
    if ((s & 3) == 0) return 2;
    if ((s & 1) == 0) return 4;
    return 8;
  endfunction

  function automatic int issue_cycle(input int k, input int s);
    int g = banks_visited(s);
    if (g >= BUSY) return k;
    return (k / g) * BUSY + (k % g);
  endfunction

  function automatic int word_at(input int a);
    return (a * 257 + 16'h1234) & 16'hFFFF;
  endfunction

  task automatic run_vec(input int b, input int s, input int n,
                         input int exp_cyc, input int exp_st, input bit poke);
    int nreq = 0;
    int nrsp = 0;
    int nst = 0;
    int guard = 0;
    @(negedge clk);
    start = 1'b1; base_addr = ADDR_W'(b); stride = ADDR_W'(s); vec_len = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 2000) begin
      if (req_valid) begin
        check("R4 req order", req_idx, nreq);
        check("R3 req addr", req_addr, (b + nreq * s) & 8'hFF);
        check("R5 issue cycle", cyc_count, issue_cycle(nreq, s));
        nreq++;
      end
      if (rsp_valid) begin
        check("R6 rsp idx", rsp_idx, nrsp);
        check("R6 rsp data", rsp_data, word_at((b + nrsp * s) & 8'hFF));
        check("R6 rsp cycle", cyc_count, issue_cycle(nrsp, s) + LAT);
        nrsp++;
      end
      if (stall) nst++;
      // R2: a second start in the middle of the load must be ignored
      if (poke && cyc_count == 5) begin
        start = 1'b1; base_addr = 8'd100; stride = 8'd1; vec_len = 8'd2;
      end else begin
        start = 1'b0;
      end
      guard++;
      @(negedge clk);
    end
    start = 1'b0;
    check("R7 done reached", done, 1);
    check("R7 total cycles", cyc_count, exp_cyc);
    check("R5 stall cycles", nst, exp_st);
    check("R4 request count", nreq, n);
    check("R6 return count", nrsp, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", done, 0);
    check("R1 reset req_valid", req_valid, 0);
    check("R1 reset stall", stall, 0);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset cyc", cyc_count, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset done", done, 0);
    check("R1 after reset cyc", cyc_count, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_vec(int'(VECS[i].base), int'(VECS[i].strd), int'(VECS[i].len),
              int'(VECS[i].cycles), int'(VECS[i].stalls), 1'b0);
    end

    // R8: done and counter hold after completion
    repeat (5) @(negedge clk);
    check("R8 done held", done, 1);
    check("R8 cyc frozen", cyc_count, 13);

    // R2: start during a running load is ignored
    run_vec(1, 8, 10, 67, 45, 1'b1);

    // R9: zero-length load, and R8 clearing of done on new start
    @(negedge clk);
    start = 1'b1; base_addr = 8'd4; stride = 8'd1; vec_len = 8'd0;
    @(negedge clk);
    start = 1'b0;
    check("R8 done cleared by start", done, 0);
    check("R2 cycle 0 count", cyc_count, 0);
    check("R9 no request", req_valid, 0);
    @(negedge clk);
    check("R9 zero length done", done, 1);
    check("R9 zero length cyc", cyc_count, 1);
    check("R9 no request later", req_valid, 0);
    check("R9 no return", rsp_valid, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule